// File: doc/BRIEF.md
# Partitioned Swap-Move Generator

This block produces the candidate moves for one iteration of a swap-based local search over a permutation of N items. The N candidate positions are cut into H equal regions, one per parallel evaluator. On each iteration the block draws a shared first index p and a random offset t from an internal linear-feedback shift register. It hands evaluator i the second index q_i = i*(N/H) + t, so every evaluator stays in its own region and never strays into another's. A move whose second index equals p is marked invalid.

The N x N cost matrix lives in H behavioural dual-port sub-memories. Sub-memory g holds the N/H rows whose index falls in region g. A row index r is stored in sub-memory r / (N/H) at local row r mod (N/H). Once the moves are out, the block streams row p to all evaluators, one column per cycle, through a multiplexer whose select is exposed. An external arbiter then reports its decision. If it accepts a valid move (p, q), the block exchanges rows p and q in the partitioned store, one column per cycle, for N cycles. `busy` is high for the whole exchange, and no new iteration can start until it drops.

Control is a four-state machine:
- S_IDLE: the ready state, in which loading is allowed. It moves to S_BCAST on `start`.
- S_BCAST: streams N beats of row p. It moves to S_WAIT after the last beat.
- S_WAIT: holds the moves. On `decide` it moves to S_SWAP for an accepted valid move, or back to S_IDLE otherwise.
- S_SWAP: runs the N-cycle exchange and then returns to S_IDLE.

Top module: `mvgen_top`

## Requirements
- R1: In the ready state, a cycle with `ld_en` high writes `ld_data` to matrix entry (`ld_row`, `ld_col`); that value is later seen on `row_data` when that row is broadcast.
- R2: After reset, `ready` is 1 and `busy`, `row_vld` and `moves_vld` are 0.
- R3: A `start` seen in the ready state draws p in [0, N) and t in [0, N/H). Move i then carries `q_out[i*IW +: IW]` = i*(N/H) + t, with IW = log2(N), so the upper log2(H) bits of q_i equal i and all moves share one offset.
- R4: `q_valid[i]` is 0 exactly when q_i equals p, so at most one flag is low.
- R5: While broadcasting, `row_sel` equals p / (N/H), the index of the sub-memory that holds row p.
- R6: The broadcast begins in the cycle after `start` is taken and lasts N consecutive cycles with `row_vld` high. `row_col` counts 0 to N-1 in order and `row_data` is matrix entry (p, `row_col`).
- R7: `moves_vld` stays high from the first broadcast beat until a decision is taken. `p_out` and `q_out` hold steady throughout, and the block waits in S_WAIT for as long as `decide` stays low.
- R8: A `decide` with `accept` high and `q_valid[pick]` high exchanges rows p and q_pick over every column. `busy` is high for exactly N cycles, and then the block is ready again.
- R9: A `decide` with `accept` low, or with `pick` naming an invalid move, returns the block to ready in the next cycle with `busy` low and leaves the matrix unchanged.
- R10: `start` while the block is not ready has no effect: the moves do not change and no new broadcast follows once the block is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Matrix write strobe, honoured only when ready |
| ld_row | input | IW | Global row of the write |
| ld_col | input | IW | Column of the write |
| ld_data | input | DW | Write data |
| start | input | 1 | Begin an iteration |
| decide | input | 1 | Arbiter decision strobe, used in S_WAIT |
| accept | input | 1 | Decision outcome: 1 accepts the picked move |
| pick | input | HW | Index of the picked move |
| ready | output | 1 | Block is in S_IDLE |
| busy | output | 1 | Row exchange in progress |
| moves_vld | output | 1 | p_out, q_out and q_valid are meaningful |
| p_out | output | IW | Shared first index |
| q_out | output | H*IW | Second index of each move, move i at bits i*IW |
| q_valid | output | H | Per-move validity flag |
| row_vld | output | 1 | Broadcast beat valid |
| row_sel | output | HW | Sub-memory select of the broadcast multiplexer |
| row_col | output | IW | Column of the current beat |
| row_data | output | DW | Matrix entry (p, row_col) |

## Verification
The assertions watch the per-cycle rules on every cycle: the broadcast column advancing by one, the moves holding steady while valid, at most one invalid flag, the exchange lasting exactly N busy cycles, and an invalid or rejected decision returning straight to ready. What they cannot show is content: whether the exchanged rows really moved and whether a loaded value appears at the right place. The bench's scenarios show this by keeping a reference matrix, applying every accepted exchange to it, and comparing each later broadcast against it. Start pulses held through the broadcast and through the exchange, and decisions that name the invalid move, are the directed cases.

// File: rtl/mvgen_pkg.sv
package mvgen_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BCAST = 2'd1,
        S_WAIT  = 2'd2,
        S_SWAP  = 2'd3
    } mg_state_t;

endpackage

// File: rtl/mvgen_lfsr.sv
module mvgen_lfsr #(
    parameter int          LW   = 16,
    parameter logic [15:0] TAPS = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1,
    parameter int          OW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [OW-1:0] draw
);

    logic [LW-1:0] sr_q;

    // Galois form, advances every cycle so draws depend on request timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= SEED[LW-1:0];
        end else begin
            sr_q <= {1'b0, sr_q[LW-1:1]} ^ (sr_q[0] ? TAPS[LW-1:0] : '0);
        end
    end

    assign draw = sr_q[OW-1:0];

endmodule

// File: rtl/mvgen_moves.sv
module mvgen_moves #(
    parameter int N = 16,
    parameter int H = 4,
    localparam int R  = N / H,
    localparam int IW = $clog2(N),
    localparam int RW = $clog2(R),
    localparam int HW = $clog2(H)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            moves_vld,
    input  logic [IW-1:0]   p,
    input  logic [RW-1:0]   t,
    output logic [H*IW-1:0] q_flat,
    output logic [H-1:0]    q_valid
);

    // Region i begins at i*R; with R a power of two the sum is a concatenation
    for (genvar i = 0; i < H; i++) begin : g_move
        localparam logic [HW-1:0] REG_IDX = HW'(i);
        logic [IW-1:0] q_i;
        assign q_i                 = {REG_IDX, t};
        assign q_flat[i*IW +: IW]  = q_i;
        assign q_valid[i]          = (q_i != p);
    end

    AST_ONE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        moves_vld |-> ($countones(~q_valid) <= 1)); // R4

endmodule

// File: rtl/mvgen_submem.sv
module mvgen_submem #(
    parameter int ROWS = 4,
    parameter int COLS = 16,
    parameter int DW   = 8,
    localparam int DEPTH = ROWS * COLS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [DW-1:0] a_wd,
    output logic [DW-1:0] a_rd,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [DW-1:0] b_wd,
    output logic [DW-1:0] b_rd
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) begin
            mem[a_addr] <= a_wd;
        end
        if (b_we) begin
            mem[b_addr] <= b_wd;
        end
    end

    // Asynchronous read lets an exchange read and write one column per cycle
    assign a_rd = mem[a_addr];
    assign b_rd = mem[b_addr];

    AST_PORT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && b_we) |-> (a_addr != b_addr)); // R8

endmodule

// File: rtl/mvgen_top.sv
module mvgen_top #(
    parameter int          N    = 16,
    parameter int          H    = 4,
    parameter int          DW   = 8,
    parameter int          LW   = 16,
    parameter logic [15:0] TAPS = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1,
    localparam int R  = N / H,
    localparam int IW = $clog2(N),
    localparam int RW = $clog2(R),
    localparam int HW = $clog2(H),
    localparam int AW = RW + IW,
    localparam int CW = IW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [IW-1:0]   ld_row,
    input  logic [IW-1:0]   ld_col,
    input  logic [DW-1:0]   ld_data,
    input  logic            start,
    input  logic            decide,
    input  logic            accept,
    input  logic [HW-1:0]   pick,
    output logic            ready,
    output logic            busy,
    output logic            moves_vld,
    output logic [IW-1:0]   p_out,
    output logic [H*IW-1:0] q_out,
    output logic [H-1:0]    q_valid,
    output logic            row_vld,
    output logic [HW-1:0]   row_sel,
    output logic [IW-1:0]   row_col,
    output logic [DW-1:0]   row_data
);
    import mvgen_pkg::*;

    localparam logic [IW-1:0] LAST_COL = IW'(N - 1);

    mg_state_t     state_q, state_d;
    logic [IW-1:0] col_q;
    logic [IW-1:0] p_q;
    logic [RW-1:0] t_q;
    logic [IW-1:0] qs_q;

    logic [IW+RW-1:0] rnd;
    logic [IW-1:0]    q_arr [H];
    logic [IW-1:0]    q_pick;
    logic             pick_ok;

    logic [HW-1:0] sp, sq, ld_sub;
    logic [RW-1:0] lp, lq;
    logic [DW-1:0] rd_a [H];
    logic [DW-1:0] rd_b [H];
    logic [DW-1:0] pdat, qdat;

    // ---------------- random source ----------------
    mvgen_lfsr #(
        .LW   (LW),
        .TAPS (TAPS),
        .SEED (SEED),
        .OW   (IW + RW)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .draw  (rnd)
    );

    // ---------------- move generation ----------------
    mvgen_moves #(
        .N (N),
        .H (H)
    ) u_moves (
        .clk       (clk),
        .rst_n     (rst_n),
        .moves_vld (moves_vld),
        .p         (p_q),
        .t         (t_q),
        .q_flat    (q_out),
        .q_valid   (q_valid)
    );

    for (genvar g = 0; g < H; g++) begin : g_unpack
        assign q_arr[g] = q_out[g*IW +: IW];
    end

    assign q_pick  = q_arr[pick];
    assign pick_ok = q_valid[pick];

    // ---------------- address split ----------------
    assign sp     = p_q[IW-1:RW];
    assign lp     = p_q[RW-1:0];
    assign sq     = qs_q[IW-1:RW];
    assign lq     = qs_q[RW-1:0];
    assign ld_sub = ld_row[IW-1:RW];

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = S_BCAST;
                end
            end
            S_BCAST: begin
                if (col_q == LAST_COL) begin
                    state_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (decide) begin
                    state_d = (accept && pick_ok) ? S_SWAP : S_IDLE;
                end
            end
            S_SWAP: begin
                if (col_q == LAST_COL) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            p_q   <= '0;
            t_q   <= '0;
            qs_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        p_q   <= rnd[IW-1:0];
                        t_q   <= rnd[IW +: RW];
                        col_q <= '0;
                    end
                end
                S_BCAST: begin
                    col_q <= col_q + IW'(1);
                end
                S_WAIT: begin
                    if (decide && accept && pick_ok) begin
                        qs_q  <= q_pick;
                        col_q <= '0;
                    end
                end
                S_SWAP: begin
                    col_q <= col_q + IW'(1);
                end
                default: col_q <= '0;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ready     = 1'b0;
        busy      = 1'b0;
        row_vld   = 1'b0;
        moves_vld = 1'b0;
        unique case (state_q)
            S_IDLE:  ready = 1'b1;
            S_BCAST: begin
                row_vld   = 1'b1;
                moves_vld = 1'b1;
            end
            S_WAIT:  moves_vld = 1'b1;
            S_SWAP:  busy = 1'b1;
            default: ready = 1'b0;
        endcase
    end

    assign p_out    = p_q;
    assign row_col  = col_q;
    assign row_sel  = sp;
    assign pdat     = rd_a[sp];
    assign qdat     = rd_b[sq];
    assign row_data = pdat;

    // ---------------- partitioned store ----------------
    for (genvar g = 0; g < H; g++) begin : g_part
        localparam logic [HW-1:0] GI = HW'(g);
        logic [AW-1:0] a_addr, b_addr;
        logic          a_we, b_we;
        logic [DW-1:0] a_wd, b_wd;

        always_comb begin
            a_addr = {lp, col_q};
            a_we   = 1'b0;
            a_wd   = ld_data;
            b_addr = {lq, col_q};
            b_we   = 1'b0;
            b_wd   = pdat;
            unique case (state_q)
                S_IDLE: begin
                    a_addr = {ld_row[RW-1:0], ld_col};
                    a_we   = ld_en && (ld_sub == GI);
                end
                S_SWAP: begin
                    a_we = (sp == GI);
                    a_wd = qdat;
                    b_we = (sq == GI);
                end
                default: a_we = 1'b0;
            endcase
        end

        mvgen_submem #(
            .ROWS (R),
            .COLS (N),
            .DW   (DW)
        ) u_mem (
            .clk    (clk),
            .rst_n  (rst_n),
            .a_addr (a_addr),
            .a_we   (a_we),
            .a_wd   (a_wd),
            .a_rd   (rd_a[g]),
            .b_addr (b_addr),
            .b_we   (b_we),
            .b_wd   (b_wd),
            .b_rd   (rd_b[g])
        );
    end

    // ---------------- checks ----------------
    logic [CW-1:0] chk_busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_busy_cnt <= '0;
        end else if (busy) begin
            chk_busy_cnt <= chk_busy_cnt + CW'(1);
        end else begin
            chk_busy_cnt <= '0;
        end
    end

    AST_STREAM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (row_vld && $past(row_vld)) |-> (row_col == $past(row_col) + IW'(1))); // R6

    AST_MOVES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (moves_vld && $past(moves_vld)) |-> ($stable(p_out) && $stable(q_out))); // R7

    AST_SWAP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_busy_cnt == CW'(N))); // R8

    AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (moves_vld && !row_vld && decide && !(accept && pick_ok)) |=> (ready && !busy)); // R9

    AST_START_NOEFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(p_out)); // R10

endmodule

// File: tb/mvgen_top_test.sv
`timescale 1ns/1ps
module mvgen_top_test;

    localparam int N  = 16;
    localparam int H  = 4;
    localparam int DW = 8;
    localparam int R  = N / H;
    localparam int IW = 4;
    localparam int HW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            ld_en;
    logic [IW-1:0]   ld_row, ld_col;
    logic [DW-1:0]   ld_data;
    logic            start, decide, accept;
    logic [HW-1:0]   pick;
    logic            ready, busy, moves_vld, row_vld;
    logic [IW-1:0]   p_out, row_col;
    logic [H*IW-1:0] q_out;
    logic [H-1:0]    q_valid;
    logic [HW-1:0]   row_sel;
    logic [DW-1:0]   row_data;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] model [N][N];

    always #2.5 clk = ~clk;

    mvgen_top #(.N(N), .H(H), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row), .ld_col(ld_col),
        .ld_data(ld_data), .start(start), .decide(decide), .accept(accept), .pick(pick),
        .ready(ready), .busy(busy), .moves_vld(moves_vld), .p_out(p_out), .q_out(q_out),
        .q_valid(q_valid), .row_vld(row_vld), .row_sel(row_sel), .row_col(row_col),
        .row_data(row_data)
    );

    function automatic int exp_q(input int i, input int t);
        return i * R + t;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    task automatic run_iter(input int it);
        logic [IW-1:0] p;
        logic [IW-1:0] qv [H];
        logic [H-1:0]  vv;
        int            t0;
        int            n_inv;
        int            inv_idx;
        logic          hold_start;
        logic          start_in_swap;
        logic          do_swap;
        int            cnt;
        logic [IW-1:0] qsel;

        hold_start    = (it % 3 == 1);
        start_in_swap = (it % 4 == 2);

        chk(ready, "R2 ready before start", ready, 1);
        start = 1'b1;
        @(negedge clk);
        if (!hold_start) start = 1'b0;

        p  = p_out;
        vv = q_valid;
        for (int i = 0; i < H; i++) qv[i] = q_out[i*IW +: IW];
        t0 = qv[0];
        chk(moves_vld && row_vld, "R6 broadcast begins", {moves_vld, row_vld}, 3);
        chk(t0 < R, "R3 offset range", t0, R - 1);
        n_inv = 0;
        inv_idx = 0;
        for (int i = 0; i < H; i++) begin
            chk(qv[i] == exp_q(i, t0), "R3 move index", qv[i], exp_q(i, t0));
            chk(vv[i] == (qv[i] != p), "R4 valid flag", vv[i], (qv[i] != p));
            if (qv[i] == p) begin
                n_inv++;
                inv_idx = i;
            end
        end
        chk(n_inv <= 1, "R4 invalid count", n_inv, 1);
        chk(row_sel == p / R, "R5 row select", row_sel, p / R);

        for (int k = 0; k < N; k++) begin
            chk(row_vld && row_col == k, "R6 column order", row_col, k);
            chk(row_data == model[p][k], (it == 0) ? "R1 loaded data" : "R6 row data",
                row_data, model[p][k]);
            chk(p_out == p, hold_start ? "R10 start during broadcast" : "R7 p stable", p_out, p);
            @(negedge clk);
        end
        start = 1'b0;

        for (int w = 0; w < (it % 3); w++) begin
            chk(moves_vld && !row_vld && !ready, "R7 waiting for decision", moves_vld, 1);
            chk(q_out == {qv[3], qv[2], qv[1], qv[0]}, "R7 moves stable", q_out,
                {qv[3], qv[2], qv[1], qv[0]});
            @(negedge clk);
        end

        if (it % 5 == 0 && n_inv == 1) begin
            pick   = HW'(inv_idx);
            accept = 1'b1;
        end else begin
            pick   = HW'($urandom % H);
            accept = ($urandom % 4) != 0;
        end
        do_swap = accept && vv[pick];
        qsel    = qv[pick];
        decide  = 1'b1;
        @(negedge clk);
        decide = 1'b0;

        if (do_swap) begin
            if (start_in_swap) start = 1'b1;
            cnt = 0;
            while (busy && cnt < 100) begin
                cnt++;
                @(negedge clk);
            end
            start = 1'b0;
            chk(cnt == N, "R8 exchange length", cnt, N);
            chk(ready && !row_vld, "R8 ready after exchange", ready, 1);
            for (int c = 0; c < N; c++) begin
                logic [DW-1:0] tmp;
                tmp          = model[p][c];
                model[p][c]  = model[qsel][c];
                model[qsel][c] = tmp;
            end
            if (start_in_swap) begin
                @(negedge clk);
                chk(!row_vld && ready, "R10 start during exchange", row_vld, 0);
            end
        end else begin
            chk(ready && !busy, "R9 reject returns ready", {ready, busy}, 2);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; ld_en = 1'b0; ld_row = '0; ld_col = '0; ld_data = '0;
        start = 1'b0; decide = 1'b0; accept = 1'b0; pick = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && !busy && !row_vld && !moves_vld, "R2 reset state",
            {ready, busy, row_vld, moves_vld}, 8);

        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                ld_en   = 1'b1;
                ld_row  = IW'(r);
                ld_col  = IW'(c);
                ld_data = DW'($urandom);
                model[r][c] = ld_data;
                @(negedge clk);
            end
        end
        ld_en = 1'b0;
        @(negedge clk);

        for (int it = 0; it < 150; it++) begin
            run_iter(it);
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

endmodule